// File: doc/BRIEF.md
# Strobe-Framed Serial Memory Host Sequencer

This block sits on the host side of a serial memory that has one data pin and three active-low strobes: chip enable, output enable and write enable. The memory takes no clock. Every bit moves in one bus cycle, and the type of that cycle (read or write) is the command. The sequencer takes a request made of a start address, a byte count and a direction. It then produces the full chain of bus cycles the memory needs, so the host logic never has to handle individual strobes.

A read request streams bytes out through a valid/ready handshake. The memory itself advances the address from one byte to the next. A write request pulls up to one page of bytes through a second valid/ready handshake, sends them, and then issues the commit pattern that starts the memory's internal programming. After a commit the sequencer stays busy for a fixed number of clocks before it takes another request. Requests that are not valid are refused with a one-clock error pulse.

Each bus cycle has two parts. In the active part, chip enable and exactly one strobe are low. In the idle part, all strobes are high. Each part lasts `PHASE_CLKS` clocks. The data pin is split into a drive value, a drive enable and a sampled input.

Top module: `smh_top`

## Requirements
- R1: Every accepted request first issues the bus cycles read, write of 0, read, in that order. No bus cycle occurs while `req_ready` is high.
- R2: Right after that opening, the address goes out as `ADDR_BITS` write cycles, most significant bit first, with no read cycle among them.
- R3: A read request collects each byte as 8 read cycles, most significant bit first. Each bit is sampled on the last clock of the cycle's active part. `rd_valid` and `rd_data` stay unchanged until `rd_ready` is taken.
- R4: After the last requested byte of a read has been handed over, exactly one write cycle of value 1 is issued. After it, `req_ready` returns high.
- R5: A write request takes each byte through `wr_valid`/`wr_ready` and sends it as 8 write cycles, most significant bit first. It sends exactly `req_count` bytes.
- R6: Right after the last data bit of a write, the cycles read, write of 1, read are issued. `req_ready` rises `PHASE_CLKS + BUSY_CYCLES + 1` clocks after chip enable rises at the end of the last of these cycles.
- R7: A request with `req_count` of 0, or a write with `req_count` above `PAGE_BYTES`, gives a one-clock `req_err` pulse, issues no bus cycle, and leaves `req_ready` high.
- R8: In each bus cycle, chip enable is low with exactly one of output enable and write enable for exactly `PHASE_CLKS` clocks. All three strobes are then high for at least `PHASE_CLKS` clocks. The two strobes are never low together.
- R9: `mem_dq_en` is high exactly while write enable is low. For a write cycle, `mem_dq_o` carries the bit being sent.
- R10: After reset, all strobes are high, `mem_dq_en`, `rd_valid`, `wr_ready` and `req_err` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and accepting a request |
| req_write | input | 1 | 1 = page write, 0 = read |
| req_addr | input | ADDR_BITS | Start byte address |
| req_count | input | CNT_W | Number of bytes to move |
| req_err | output | 1 | One-clock pulse when a request is refused |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Sequencer takes the write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Host takes the read byte |
| rd_data | output | 8 | Read byte |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_o | output | 1 | Value driven onto the data pin |
| mem_dq_en | output | 1 | Drive enable for the data pin |
| mem_dq_i | input | 1 | Value sampled from the data pin |

## Verification
Some properties are checked on every clock: only one strobe is low at a time, the strobes only go low inside chip enable, there is an idle gap after each cycle, the data pin is driven exactly during write strobes, read bytes stay stable while stalled, and a refused request leaves the bus quiet. Other properties can only be shown by the bench scenarios. These are the order and content of whole cycle chains (opening, address bits, data bits, read stop, commit), the exact length of the busy period after a commit, and byte values assembled from a memory model that wraps at the top of the address space. The bench checks these over a sweep of write lengths up to a full page and reads at several start addresses.

// File: rtl/smh_pkg.sv
package smh_pkg;

    // Bus-cycle engine states
    typedef enum logic [1:0] {
        PHY_IDLE,
        PHY_ACT,
        PHY_GAP
    } phy_state_e;

    // Request sequencer states
    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_PRE,
        SQ_ADDR,
        SQ_RDBIT,
        SQ_RDOUT,
        SQ_RDEND,
        SQ_WRGET,
        SQ_WRBIT,
        SQ_COMMIT,
        SQ_HOLD
    } seq_state_e;

    // One bus cycle: its type and, for a write, the bit
    typedef struct packed {
        logic wr;
        logic dat;
    } bus_op_t;

    localparam int unsigned BYTE_BITS = 8;
    localparam int unsigned TRIO_LEN  = 3;

endpackage

// File: rtl/smh_phy.sv
module smh_phy
    import smh_pkg::*;
#(
    parameter int unsigned PHASE_CLKS = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    go,
    input  bus_op_t op,
    input  logic    dq_i,
    output logic    done,
    output logic    rbit,
    output logic    ce_n,
    output logic    oe_n,
    output logic    we_n,
    output logic    dq_o,
    output logic    dq_en
);

    localparam int unsigned PW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
    localparam logic [PW-1:0] LAST = PW'(PHASE_CLKS - 1);

    typedef struct packed {
        phy_state_e    st;
        logic [PW-1:0] cnt;
        bus_op_t       op;
        logic          rbit;
    } phy_reg_t;

    phy_reg_t r_q, r_d;
    logic     active;

    always_comb begin
        r_d  = r_q;
        done = 1'b0;
        unique case (r_q.st)
            PHY_IDLE: begin
                if (go) begin
                    r_d.st  = PHY_ACT;
                    r_d.cnt = '0;
                    r_d.op  = op;
                end
            end
            PHY_ACT: begin
                if (r_q.cnt == LAST) begin
                    r_d.st  = PHY_GAP;
                    r_d.cnt = '0;
                    if (!r_q.op.wr) begin
                        r_d.rbit = dq_i;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            PHY_GAP: begin
                if (r_q.cnt == LAST) begin
                    r_d.st = PHY_IDLE;
                    done   = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = PHY_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= PHY_IDLE;
            r_q.cnt  <= '0;
            r_q.op   <= '0;
            r_q.rbit <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign active = (r_q.st == PHY_ACT);
    assign ce_n   = !active;
    assign oe_n   = !(active && !r_q.op.wr);
    assign we_n   = !(active && r_q.op.wr);
    assign dq_en  = active && r_q.op.wr;
    assign dq_o   = r_q.op.dat;
    assign rbit   = r_q.rbit;

endmodule

// File: rtl/smh_seq.sv
module smh_seq
    import smh_pkg::*;
#(
    parameter int unsigned ADDR_BITS   = 16,
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned PAGE_BYTES  = 64,
    parameter int unsigned BUSY_CYCLES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_BITS-1:0] req_addr,
    input  logic [CNT_W-1:0]     req_count,
    output logic                 req_err,
    input  logic                 wr_valid,
    output logic                 wr_ready,
    input  logic [7:0]           wr_data,
    output logic                 rd_valid,
    input  logic                 rd_ready,
    output logic [7:0]           rd_data,
    output logic                 go,
    output bus_op_t              op,
    input  logic                 done,
    input  logic                 rbit
);

    localparam int unsigned IDX_W = $clog2(ADDR_BITS + 1);
    localparam int unsigned TMR_W = (BUSY_CYCLES > 0) ? $clog2(BUSY_CYCLES + 1) : 1;
    localparam logic [CNT_W-1:0] PAGE_LIM  = CNT_W'(PAGE_BYTES);
    localparam logic [CNT_W-1:0] ONE_LEFT  = CNT_W'(1);
    localparam logic [IDX_W-1:0] ADDR_LAST = IDX_W'(ADDR_BITS - 1);
    localparam logic [IDX_W-1:0] BYTE_LAST = IDX_W'(BYTE_BITS - 1);
    localparam logic [IDX_W-1:0] TRIO_LAST = IDX_W'(TRIO_LEN - 1);
    localparam logic [IDX_W-1:0] TRIO_MID  = IDX_W'(1);
    localparam logic [TMR_W-1:0] HOLD_LOAD = TMR_W'(BUSY_CYCLES);

    typedef struct packed {
        seq_state_e           st;
        logic [IDX_W-1:0]     idx;
        logic [CNT_W-1:0]     cnt;
        logic [ADDR_BITS-1:0] sh;
        logic                 wmode;
        logic                 pend;
        logic [TMR_W-1:0]     tmr;
        logic                 err;
    } seq_reg_t;

    seq_reg_t r_q, r_d;
    logic     bus_state;

    // Which bus cycle the current state asks for
    always_comb begin
        op        = '0;
        bus_state = 1'b1;
        unique case (r_q.st)
            SQ_PRE:    begin op.wr = (r_q.idx == TRIO_MID); op.dat = 1'b0; end
            SQ_ADDR:   begin op.wr = 1'b1; op.dat = r_q.sh[ADDR_BITS-1]; end
            SQ_RDBIT:  begin op.wr = 1'b0; op.dat = 1'b0; end
            SQ_RDEND:  begin op.wr = 1'b1; op.dat = 1'b1; end
            SQ_WRBIT:  begin op.wr = 1'b1; op.dat = r_q.sh[BYTE_BITS-1]; end
            SQ_COMMIT: begin op.wr = (r_q.idx == TRIO_MID); op.dat = 1'b1; end
            default:   bus_state = 1'b0;
        endcase
    end

    always_comb begin
        r_d       = r_q;
        r_d.err   = 1'b0;
        go        = 1'b0;
        req_ready = 1'b0;
        wr_ready  = 1'b0;
        rd_valid  = 1'b0;
        rd_data   = r_q.sh[BYTE_BITS-1:0];

        if (bus_state && !r_q.pend) begin
            go       = 1'b1;
            r_d.pend = 1'b1;
        end
        if (done) begin
            r_d.pend = 1'b0;
        end

        unique case (r_q.st)
            SQ_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    if ((req_count == '0) || (req_write && (req_count > PAGE_LIM))) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.st    = SQ_PRE;
                        r_d.idx   = '0;
                        r_d.cnt   = req_count;
                        r_d.sh    = req_addr;
                        r_d.wmode = req_write;
                    end
                end
            end
            SQ_PRE: begin
                if (done) begin
                    if (r_q.idx == TRIO_LAST) begin
                        r_d.st  = SQ_ADDR;
                        r_d.idx = '0;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            SQ_ADDR: begin
                if (done) begin
                    r_d.sh = {r_q.sh[ADDR_BITS-2:0], 1'b0};
                    if (r_q.idx == ADDR_LAST) begin
                        r_d.idx = '0;
                        r_d.st  = r_q.wmode ? SQ_WRGET : SQ_RDBIT;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            SQ_RDBIT: begin
                if (done) begin
                    r_d.sh = {r_q.sh[ADDR_BITS-2:0], rbit};
                    if (r_q.idx == BYTE_LAST) begin
                        r_d.st = SQ_RDOUT;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            SQ_RDOUT: begin
                rd_valid = 1'b1;
                if (rd_ready) begin
                    if (r_q.cnt == ONE_LEFT) begin
                        r_d.st = SQ_RDEND;
                    end else begin
                        r_d.cnt = r_q.cnt - 1'b1;
                        r_d.st  = SQ_RDBIT;
                        r_d.idx = '0;
                    end
                end
            end
            SQ_RDEND: begin
                if (done) begin
                    r_d.st = SQ_IDLE;
                end
            end
            SQ_WRGET: begin
                wr_ready = 1'b1;
                if (wr_valid) begin
                    r_d.sh[BYTE_BITS-1:0] = wr_data;
                    r_d.st  = SQ_WRBIT;
                    r_d.idx = '0;
                end
            end
            SQ_WRBIT: begin
                if (done) begin
                    r_d.sh = {r_q.sh[ADDR_BITS-2:0], 1'b0};
                    if (r_q.idx == BYTE_LAST) begin
                        if (r_q.cnt == ONE_LEFT) begin
                            r_d.st  = SQ_COMMIT;
                            r_d.idx = '0;
                        end else begin
                            r_d.cnt = r_q.cnt - 1'b1;
                            r_d.st  = SQ_WRGET;
                        end
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            SQ_COMMIT: begin
                if (done) begin
                    if (r_q.idx == TRIO_LAST) begin
                        r_d.st  = SQ_HOLD;
                        r_d.tmr = HOLD_LOAD;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            SQ_HOLD: begin
                if (r_q.tmr == '0) begin
                    r_d.st = SQ_IDLE;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            default: r_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= SQ_IDLE;
            r_q.idx   <= '0;
            r_q.cnt   <= '0;
            r_q.sh    <= '0;
            r_q.wmode <= 1'b0;
            r_q.pend  <= 1'b0;
            r_q.tmr   <= '0;
            r_q.err   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_err = r_q.err;

endmodule

// File: rtl/smh_top.sv
module smh_top
    import smh_pkg::*;
#(
    parameter int unsigned ADDR_BITS   = 16,
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned PAGE_BYTES  = 64,
    parameter int unsigned PHASE_CLKS  = 2,
    parameter int unsigned BUSY_CYCLES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_BITS-1:0] req_addr,
    input  logic [CNT_W-1:0]     req_count,
    output logic                 req_err,
    input  logic                 wr_valid,
    output logic                 wr_ready,
    input  logic [7:0]           wr_data,
    output logic                 rd_valid,
    input  logic                 rd_ready,
    output logic [7:0]           rd_data,
    output logic                 mem_ce_n,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic                 mem_dq_o,
    output logic                 mem_dq_en,
    input  logic                 mem_dq_i
);

    logic    cyc_go;
    logic    cyc_done;
    logic    cyc_rbit;
    bus_op_t cyc_op;

    smh_seq #(
        .ADDR_BITS  (ADDR_BITS),
        .CNT_W      (CNT_W),
        .PAGE_BYTES (PAGE_BYTES),
        .BUSY_CYCLES(BUSY_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_count(req_count),
        .req_err  (req_err),
        .wr_valid (wr_valid),
        .wr_ready (wr_ready),
        .wr_data  (wr_data),
        .rd_valid (rd_valid),
        .rd_ready (rd_ready),
        .rd_data  (rd_data),
        .go       (cyc_go),
        .op       (cyc_op),
        .done     (cyc_done),
        .rbit     (cyc_rbit)
    );

    smh_phy #(
        .PHASE_CLKS(PHASE_CLKS)
    ) u_phy (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (cyc_go),
        .op   (cyc_op),
        .dq_i (mem_dq_i),
        .done (cyc_done),
        .rbit (cyc_rbit),
        .ce_n (mem_ce_n),
        .oe_n (mem_oe_n),
        .we_n (mem_we_n),
        .dq_o (mem_dq_o),
        .dq_en(mem_dq_en)
    );

endmodule

// File: rtl/smh_checker.sv
module smh_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_ce_n,
    input logic       mem_oe_n,
    input logic       mem_we_n,
    input logic       mem_dq_en,
    input logic       req_ready,
    input logic       req_err,
    input logic       wr_ready,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic [7:0] rd_data
);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n)); // R8

    AST_STROBE_IN_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> !mem_ce_n); // R8

    AST_CE_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> (mem_oe_n != mem_we_n)); // R8

    AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |=> mem_ce_n); // R8

    AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_en |-> (!mem_we_n && !mem_ce_n)); // R9

    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_en); // R9

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R3

    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (mem_ce_n && req_ready)); // R7

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !rd_valid && !wr_ready)); // R1

endmodule

bind smh_top smh_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_ce_n (mem_ce_n),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .mem_dq_en(mem_dq_en),
    .req_ready(req_ready),
    .req_err  (req_err),
    .wr_ready (wr_ready),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data)
);

// File: tb/smh_top_test.sv
`timescale 1ns/1ps
module smh_top_test;

    localparam int PH   = 2;
    localparam int BUSY = 5;
    localparam int PAGE = 8;
    localparam int AW   = 16;
    localparam int CW   = 8;
    localparam int LOGN = 200;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_count = '0;
    logic          req_err;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [7:0]    wr_data = '0;
    logic          rd_valid;
    logic          rd_ready = 1'b0;
    logic [7:0]    rd_data;
    logic          ce_n, oe_n, we_n, dq_o, dq_en;
    logic          dq_i = 1'b1;

    smh_top #(
        .ADDR_BITS(AW), .CNT_W(CW), .PAGE_BYTES(PAGE),
        .PHASE_CLKS(PH), .BUSY_CYCLES(BUSY)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_count(req_count), .req_err(req_err),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .mem_ce_n(ce_n), .mem_oe_n(oe_n), .mem_we_n(we_n),
        .mem_dq_o(dq_o), .mem_dq_en(dq_en), .mem_dq_i(dq_i)
    );

    always #4 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // bus monitor and memory model state
    logic          log_t [0:LOGN-1];
    logic          log_b [0:LOGN-1];
    logic          exp_t [0:LOGN-1];
    logic          exp_b [0:LOGN-1];
    int            log_n = 0;
    int            exp_n = 0;
    int            bad_frame = 0;
    int            bad_drive = 0;
    int            act_len = 0;
    int            rd_idx = 0;
    int            t_rise = 0;
    logic          prev_ce = 1'b1;
    logic [AW-1:0] op_addr = '0;

    function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
        return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] wr_byte(input logic [AW-1:0] a, input int k);
        return 8'(a[7:0] + 8'(k * 3) + 8'h11);
    endfunction

    function automatic logic rd_bit(input int idx);
        logic [AW-1:0] a;
        logic [7:0]    b;
        if (idx < 2) return 1'b1;
        a = op_addr + AW'((idx - 2) / 8);
        b = mem_byte(a);
        return b[7 - ((idx - 2) % 8)];
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ce && !ce_n) begin
                if (log_n < LOGN) begin
                    log_t[log_n] = !we_n;
                    log_b[log_n] = dq_o;
                    log_n++;
                end
                act_len = 1;
                if (!oe_n) begin
                    dq_i = rd_bit(rd_idx);
                    rd_idx++;
                end
            end else if (!ce_n) begin
                act_len++;
            end
            if (!prev_ce && ce_n) begin
                if (act_len != PH) bad_frame++;
                t_rise = cyc;
            end
            if (!ce_n && (oe_n == we_n)) bad_frame++;
            if (ce_n && (!oe_n || !we_n)) bad_frame++;
            if (dq_en != !we_n) bad_drive++;
            prev_ce = ce_n;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic t, input logic b);
        exp_t[exp_n] = t;
        exp_b[exp_n] = b;
        exp_n++;
    endtask

    task automatic build_expect(input bit w, input logic [AW-1:0] a, input int n);
        exp_n = 0;
        push(1'b0, 1'b0); push(1'b1, 1'b0); push(1'b0, 1'b0);
        for (int i = AW - 1; i >= 0; i--) push(1'b1, a[i]);
        if (w) begin
            for (int k = 0; k < n; k++) begin
                logic [7:0] d;
                d = wr_byte(a, k);
                for (int i = 7; i >= 0; i--) push(1'b1, d[i]);
            end
            push(1'b0, 1'b0); push(1'b1, 1'b1); push(1'b0, 1'b0);
        end else begin
            for (int k = 0; k < n * 8; k++) push(1'b0, 1'b0);
            push(1'b1, 1'b1);
        end
    endtask

    task automatic compare_log(input bit w);
        int bad_pre, bad_adr, bad_body, bad_tail, tail_len;
        bad_pre = 0; bad_adr = 0; bad_body = 0; bad_tail = 0;
        tail_len = w ? 3 : 1;
        for (int i = 0; i < exp_n; i++) begin
            bit mis;
            if (i < log_n)
                mis = (log_t[i] != exp_t[i]) || (exp_t[i] && (log_b[i] != exp_b[i]));
            else
                mis = 1'b1;
            if (mis) begin
                if (i < 3) bad_pre++;
                else if (i < 3 + AW) bad_adr++;
                else if (i < exp_n - tail_len) bad_body++;
                else bad_tail++;
            end
        end
        chk(bad_pre == 0, "R1 opening read/write0/read", bad_pre, 0);
        chk(bad_adr == 0, "R2 address bits msb first", bad_adr, 0);
        chk(bad_body == 0, w ? "R5 write data bits" : "R3 read data cycles", bad_body, 0);
        chk(bad_tail == 0, w ? "R6 commit read/write1/read" : "R4 read stop write1", bad_tail, 0);
        chk(log_n == exp_n, w ? "R5 total cycle count" : "R4 total cycle count", log_n, exp_n);
        chk(bad_frame == 0, "R8 strobe framing", bad_frame, 0);
        chk(bad_drive == 0, "R9 data pin drive", bad_drive, 0);
    endtask

    task automatic do_op(input bit w, input logic [AW-1:0] a, input int n);
        @(negedge clk);
        log_n = 0; rd_idx = 0; bad_frame = 0; bad_drive = 0; op_addr = a;
        req_valid = 1'b1; req_write = w; req_addr = a; req_count = CW'(n);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (w) begin
            for (int k = 0; k < n; k++) begin
                wr_valid = 1'b1;
                wr_data  = wr_byte(a, k);
                while (!wr_ready) @(negedge clk);
                @(posedge clk);
                @(negedge clk);
                wr_valid = 1'b0;
                repeat (k % 2) @(negedge clk);
            end
        end else begin
            for (int k = 0; k < n; k++) begin
                logic [7:0] e;
                while (!rd_valid) @(negedge clk);
                repeat (k % 3) @(negedge clk);
                e = mem_byte(a + AW'(k));
                chk(rd_data == e, "R3 read byte value", rd_data, e);
                rd_ready = 1'b1;
                @(posedge clk);
                @(negedge clk);
                rd_ready = 1'b0;
            end
        end
        while (!req_ready) @(negedge clk);
        if (w) chk((cyc - t_rise) == PH + BUSY + 1, "R6 busy hold length", cyc - t_rise, PH + BUSY + 1);
        build_expect(w, a, n);
        compare_log(w);
    endtask

    task automatic do_reject(input bit w, input int n);
        @(negedge clk);
        log_n = 0;
        req_valid = 1'b1; req_write = w; req_addr = 16'h0123; req_count = CW'(n);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_err == 1'b1, "R7 error pulse", req_err, 1);
        chk(req_ready == 1'b1, "R7 stays ready", req_ready, 1);
        @(negedge clk);
        chk(req_err == 1'b0, "R7 pulse one clock", req_err, 0);
        repeat (10) @(negedge clk);
        chk(log_n == 0, "R7 no bus cycles", log_n, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ce_n && oe_n && we_n && !dq_en && !req_err && !rd_valid && !wr_ready && req_ready,
            "R10 reset outputs", {ce_n, oe_n, we_n, dq_en, req_err, rd_valid, wr_ready, req_ready},
            8'b11100001);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ce_n && req_ready && !req_err, "R10 idle after reset", {ce_n, req_ready, req_err}, 3'b110);

        do_op(1'b0, 16'h0000, 1);
        do_op(1'b0, 16'h1234, 3);
        do_op(1'b0, 16'hFFFE, 4);
        do_op(1'b0, 16'h00FF, 2);
        for (int n = 1; n <= PAGE; n++) do_op(1'b1, AW'(n * 16'h0101), n);

        do_reject(1'b1, 0);
        do_reject(1'b1, PAGE + 1);
        do_reject(1'b1, 200);
        do_reject(1'b0, 0);

        do_op(1'b0, 16'h8000, 2);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule